// File: doc/BRIEF.md
# Word-Mode SPI Master with Hardware Packet Counter

This block is a memory-mapped SPI master channel that moves whole 32-bit words. Firmware writes a word count into the packet register. The shift engine then clocks that many words on the bus and collects each received word into a 16-entry receive FIFO. When the swap options are set, each received word is reordered by byte and halfword before it is stored. Words written to the transmit FIFO go out first. Once that FIFO is empty, the engine sends all-ones filler, so a read keeps the bus clocked with no software involvement.

The select line is under software control through a register. A soft-reset bit flushes both FIFOs and returns the engine to idle. A status register reports both FIFO fill levels, a transmit-done flag and a sticky underrun flag.

The engine is one state machine. Its states are ENG_IDLE, ENG_STALL, ENG_SETUP, ENG_ACTIVE and ENG_COMMIT, and its transitions are:
- **start**: ENG_IDLE to ENG_SETUP, taken when work is pending and the receive FIFO has room. On this transition the shifter is loaded.
- **block**: ENG_IDLE to ENG_STALL, taken when work is pending but the receive FIFO is full.
- **resume**: ENG_STALL to ENG_SETUP, taken when room appears.
- **abandon**: ENG_STALL to ENG_IDLE, taken when the pending work disappears.
- **lead**: ENG_SETUP to ENG_ACTIVE, after one half period. The serial input is sampled on this transition.
- **trail**: ENG_ACTIVE to ENG_SETUP, after one half period, for bits 0 to 30. The shifter advances.
- **last**: ENG_ACTIVE to ENG_COMMIT, after bit 31.
- **retire**: ENG_COMMIT to ENG_IDLE. The received word is pushed and the packet count drops by one.

A soft reset forces ENG_IDLE from any state.

Top module: `wspi_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, the packet register reads 0, and STATUS reads 32'h0000_0001.
- R2: Writing PKT (address 2) with bit 16 = 1 and count[15:0] = N clocks exactly N words. The remaining count reads back in bits [15:0], drops by one as each word completes, and the engine goes idle at zero.
- R3: STATUS (address 3) has these fields: bit 0 is transmit-done (transmit FIFO empty and shifter idle), bit 1 is underrun, bits [12:6] are the transmit FIFO level, and bits [21:15] are the receive FIFO level. All other bits are zero.
- R4: Bits are sent and received most significant bit first. The serial output changes only while spi_sclk is at its idle level, and the serial input is sampled on the leading clock edge.
- R5: When the transmit FIFO is empty, each clocked word sends 32'hFFFF_FFFF.
- R6: Words written to TXDATA (address 4) are sent in order, ahead of any filler. Transmit-done is set once they have all gone out.
- R7: SWAP (address 1) has bit 0 = enable, bit 1 = swap the bytes inside each halfword, and bit 2 = swap the halfwords. With both swap bits set, the byte order is fully reversed. When enable is 0, the word is stored unchanged.
- R8: A word is started only when the receive FIFO has room. With the FIFO full (16 words), the clock stays idle and the count is held, and the transfer resumes without loss after reads.
- R9: Reading RXDATA (address 5) while the receive FIFO is empty returns 0 and sets the underrun bit. That bit stays set until a soft reset.
- R10: CTRL (address 0) bit 3 is the soft reset. While it is set, both FIFOs are emptied, the engine is idle and underrun is cleared.
- R11: CS (address 6) bit 0 is the inactive bit and resets to 1. spi_cs_n follows this bit.
- R12: CTRL bit 2 = 1 makes spi_sclk idle high. With bit 2 = 0, spi_sclk idles low.
- R13: CTRL bit 0 enables transmit: with it at 0, no word is clocked, and the transmit FIFO and the count are held. CTRL bit 1 enables receive: with it at 0, completed words are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RXDATA) |
| reg_addr | input | 3 | Word register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Most internal faults show up on the serial pins or in the status word within one word time (about 130 cycles):
- **Bit counter or shifter fault**: received words come out rotated or shifted, and the captured output stream misaligns.
- **Swap-select fault**: the bytes in the words read back from RXDATA are permuted.
- **Packet counter or room check fault**: the readback count goes wrong, or the receive level exceeds 16 while spi_sclk keeps toggling during a stall. Either shows at the next status poll.
- **Flag fault**: a wrong underrun or transmit-done state appears in STATUS on the very next read.

// File: rtl/wspi_pkg.sv
package wspi_pkg;
    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_SWAP = 3'd1;
    localparam logic [REG_AW-1:0] A_PKT  = 3'd2;
    localparam logic [REG_AW-1:0] A_STAT = 3'd3;
    localparam logic [REG_AW-1:0] A_TXD  = 3'd4;
    localparam logic [REG_AW-1:0] A_RXD  = 3'd5;
    localparam logic [REG_AW-1:0] A_CS   = 3'd6;

    localparam int unsigned CTRL_TXON = 0;
    localparam int unsigned CTRL_RXON = 1;
    localparam int unsigned CTRL_CPOL = 2;
    localparam int unsigned CTRL_SRST = 3;

    localparam int unsigned SWP_EN   = 0;
    localparam int unsigned SWP_BYTE = 1;
    localparam int unsigned SWP_HALF = 2;

    localparam int unsigned PKT_EN_BIT = 16;

    localparam int unsigned ST_TXDONE   = 0;
    localparam int unsigned ST_UNDERRUN = 1;
    localparam int unsigned ST_TXLVL    = 6;
    localparam int unsigned ST_RXLVL    = 15;
    localparam int unsigned ST_LVL_W    = 7;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_STALL,
        ENG_SETUP,
        ENG_ACTIVE,
        ENG_COMMIT
    } eng_state_e;
endpackage

// File: rtl/wspi_fifo.sv
module wspi_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     pop,
    output logic [WIDTH-1:0]         rdata,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned LVL_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             push_ok, pop_ok;

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign level   = count;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LVL_W'(DEPTH));
endmodule

// File: rtl/wspi_reorder.sv
module wspi_reorder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             en,
    input  logic             byte_sw,
    input  logic             half_sw,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LANES  = WIDTH / 8;
    localparam int unsigned LANE_W = $clog2(LANES);

    logic [LANE_W-1:0] sel;
    assign sel = en ? LANE_W'({half_sw, byte_sw}) : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] src;
        assign src = LANE_W'(i) ^ sel;
        assign dout[i*8 +: 8] = din[{src, 3'b000} +: 8];
    end
endmodule

// File: rtl/wspi_shift_engine.sv
module wspi_shift_engine
    import wspi_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tx_on,
    input  logic              rx_on,
    input  logic              cpol,
    input  logic              work_pend,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rx_room,
    input  logic              miso,
    output logic              tx_pop,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam int unsigned HC_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    eng_state_e        st, st_nx;
    logic [HC_W-1:0]   half_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic              half_last, last_bit, go, room_ok, load;

    assign half_last = (half_cnt == HC_W'(HALF_CYC - 1));
    assign last_bit  = (bit_cnt == BIT_W'(WORD_W - 1));
    assign go        = tx_on && work_pend;
    assign room_ok   = !rx_on || rx_room;
    assign load      = ((st == ENG_IDLE) || (st == ENG_STALL)) && (st_nx == ENG_SETUP);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ENG_IDLE: begin
                if (go) st_nx = room_ok ? ENG_SETUP : ENG_STALL;
            end
            ENG_STALL: begin
                if (!go)          st_nx = ENG_IDLE;
                else if (room_ok) st_nx = ENG_SETUP;
            end
            ENG_SETUP: begin
                if (half_last) st_nx = ENG_ACTIVE;
            end
            ENG_ACTIVE: begin
                if (half_last) st_nx = last_bit ? ENG_COMMIT : ENG_SETUP;
            end
            ENG_COMMIT: st_nx = ENG_IDLE;
            default:    st_nx = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st <= ENG_IDLE;
        else if (flush) st <= ENG_IDLE;
        else            st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bit_cnt  <= '0;
            tx_sh    <= '1;
            rx_sh    <= '0;
        end else if (flush) begin
            half_cnt <= '0;
            bit_cnt  <= '0;
            tx_sh    <= '1;
        end else begin
            half_cnt <= (st_nx != st) ? '0 : half_cnt + 1'b1;
            if (load) begin
                tx_sh   <= tx_avail ? tx_word : '1;
                bit_cnt <= '0;
            end
            if (st == ENG_SETUP && half_last) begin
                rx_sh <= {rx_sh[WORD_W-2:0], miso};
            end
            if (st == ENG_ACTIVE && half_last && !last_bit) begin
                tx_sh   <= {tx_sh[WORD_W-2:0], 1'b1};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sclk      = cpol ^ (st == ENG_ACTIVE);
        mosi      = (st == ENG_SETUP || st == ENG_ACTIVE) ? tx_sh[WORD_W-1] : 1'b1;
        word_done = (st == ENG_COMMIT);
        busy      = (st == ENG_SETUP) || (st == ENG_ACTIVE) || (st == ENG_COMMIT);
        tx_pop    = load && tx_avail;
        rx_word   = rx_sh;
    end

    assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (st == ENG_ACTIVE && $past(st) == ENG_ACTIVE) |-> $stable(mosi));
    assert_pop_needs_txon_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_on);
endmodule

// File: rtl/wspi_master.sv
module wspi_master
    import wspi_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned HALF_CYC   = 2,
    parameter int unsigned PKT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LVL_W  = $clog2(FIFO_DEPTH) + 1;

    logic             tx_on, rx_on, cpol, srst;
    logic             swp_en, swp_byte, swp_half;
    logic             pkt_en;
    logic [PKT_W-1:0] pkt_cnt;
    logic             cs_inact, underrun;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [WORD_W-1:0] tx_head;
    logic [LVL_W-1:0]  tx_lvl;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [WORD_W-1:0] rx_head, rx_raw, rx_swapped;
    logic [LVL_W-1:0]  rx_lvl;
    logic              word_done, busy, work_pend, tx_done;
    logic              wr_pkt, rd_rxd;
    logic [31:0]       status;

    assign wr_pkt    = reg_we && (reg_addr == A_PKT);
    assign rd_rxd    = reg_re && (reg_addr == A_RXD);
    assign tx_push   = reg_we && (reg_addr == A_TXD) && !tx_full;
    assign rx_pop    = rd_rxd && !rx_empty;
    assign rx_push   = word_done && rx_on;
    assign work_pend = !tx_empty || (pkt_en && (pkt_cnt != '0));
    assign tx_done   = tx_empty && !busy;

    wspi_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk, .rst_n, .flush(srst),
        .push(tx_push), .wdata(reg_wdata), .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .level(tx_lvl)
    );

    wspi_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk, .rst_n, .flush(srst),
        .push(rx_push), .wdata(rx_swapped), .pop(rx_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty), .level(rx_lvl)
    );

    wspi_reorder #(.WIDTH(WORD_W)) u_swap (
        .en(swp_en), .byte_sw(swp_byte), .half_sw(swp_half),
        .din(rx_raw), .dout(rx_swapped)
    );

    wspi_shift_engine #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) u_eng (
        .clk, .rst_n, .flush(srst),
        .tx_on, .rx_on, .cpol, .work_pend,
        .tx_avail(!tx_empty), .tx_word(tx_head), .rx_room(!rx_full),
        .miso(spi_miso), .tx_pop, .word_done, .rx_word(rx_raw),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy
    );

    // register block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_on    <= 1'b0;
            rx_on    <= 1'b0;
            cpol     <= 1'b0;
            srst     <= 1'b0;
            swp_en   <= 1'b0;
            swp_byte <= 1'b0;
            swp_half <= 1'b0;
            pkt_en   <= 1'b0;
            pkt_cnt  <= '0;
            cs_inact <= 1'b1;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    A_CTRL: begin
                        tx_on <= reg_wdata[CTRL_TXON];
                        rx_on <= reg_wdata[CTRL_RXON];
                        cpol  <= reg_wdata[CTRL_CPOL];
                        srst  <= reg_wdata[CTRL_SRST];
                    end
                    A_SWAP: begin
                        swp_en   <= reg_wdata[SWP_EN];
                        swp_byte <= reg_wdata[SWP_BYTE];
                        swp_half <= reg_wdata[SWP_HALF];
                    end
                    A_CS:    cs_inact <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (wr_pkt) begin
                pkt_en  <= reg_wdata[PKT_EN_BIT];
                pkt_cnt <= reg_wdata[PKT_W-1:0];
            end else if (word_done && pkt_en && (pkt_cnt != '0)) begin
                pkt_cnt <= pkt_cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  underrun <= 1'b0;
        else if (srst)               underrun <= 1'b0;
        else if (rd_rxd && rx_empty) underrun <= 1'b1;
    end

    always_comb begin
        status = '0;
        status[ST_TXDONE]               = tx_done;
        status[ST_UNDERRUN]             = underrun;
        status[ST_TXLVL +: ST_LVL_W]    = ST_LVL_W'(tx_lvl);
        status[ST_RXLVL +: ST_LVL_W]    = ST_LVL_W'(rx_lvl);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {28'd0, srst, cpol, rx_on, tx_on};
            A_SWAP:  reg_rdata = {29'd0, swp_half, swp_byte, swp_en};
            A_PKT:   reg_rdata = 32'({pkt_en, pkt_cnt});
            A_STAT:  reg_rdata = status;
            A_RXD:   reg_rdata = rx_empty ? '0 : rx_head;
            A_CS:    reg_rdata = {31'd0, cs_inact};
            default: reg_rdata = '0;
        endcase
    end

    assign spi_cs_n = cs_inact;

    assert_rx_push_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    assert_pkt_nonincrease_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pkt |=> (pkt_cnt <= $past(pkt_cnt)));
    assert_txdone_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_TXDONE] |-> (status[ST_TXLVL +: ST_LVL_W] == '0));
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !srst) |=> underrun);
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (rx_lvl == '0 && tx_lvl == '0));
endmodule

// File: tb/wspi_master_test.sv
module wspi_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wspi_master uut (
        .clk, .rst_n, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
        .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n
    );

    function automatic logic [31:0] pat(input int k);
        return 32'h1F2E3D4C ^ (32'(k) * 32'h9E3779B9);
    endfunction

    function automatic logic [31:0] exp_swap(input logic [2:0] cfg, input logic [31:0] w);
        if (!cfg[0]) return w;
        case (cfg[2:1])
            2'b01:   return {w[23:16], w[31:24], w[7:0], w[15:8]};
            2'b10:   return {w[15:0], w[31:16]};
            2'b11:   return {w[7:0], w[15:8], w[23:16], w[31:24]};
            default: return w;
        endcase
    endfunction

    // serial device model: sends pat(word) MSB first, logs received words
    int          s_word = 0;
    int          s_bit = 0;
    logic [31:0] s_sh = '0;
    logic [31:0] cap [64];
    logic [31:0] cur_pat;

    assign cur_pat  = pat(s_word);
    assign spi_miso = cur_pat[31 - s_bit];

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (s_bit == 31) begin
                cap[s_word % 64] = {s_sh[30:0], spi_mosi};
                s_bit  = 0;
                s_word = s_word + 1;
            end else begin
                s_sh  = {s_sh[30:0], spi_mosi};
                s_bit = s_bit + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] p, s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd2, p);
            rd(3'd3, s);
            if (p[15:0] == 16'd0 && s[0]) break;
        end
    endtask

    // {swap cfg[2:0] (en, byte, half), word count}
    localparam logic [5:0] VECS [6] = '{
        {3'b000, 3'd1}, {3'b011, 3'd2}, {3'b101, 3'd3},
        {3'b111, 3'd4}, {3'b010, 3'd2}, {3'b001, 3'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 sclk", 32'(spi_sclk), 32'd0);
        rd(3'd2, v); check("R1 pkt", v, 32'd0);
        rd(3'd3, v); check("R1 status", v, 32'h1);

        // R12 clock polarity (select high, model ignores edges)
        wr(3'd0, 32'h4); @(negedge clk);
        check("R12 idle high", 32'(spi_sclk), 32'd1);
        wr(3'd0, 32'h0); @(negedge clk);
        check("R12 idle low", 32'(spi_sclk), 32'd0);

        // R11 select control
        wr(3'd6, 32'h0); @(negedge clk);
        check("R11 cs low", 32'(spi_cs_n), 32'd0);
        wr(3'd6, 32'h1); @(negedge clk);
        check("R11 cs high", 32'(spi_cs_n), 32'd1);
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h3);

        // R2 R4 R7 vector table
        foreach (VECS[j]) begin
            base = s_word;
            wr(3'd1, 32'(VECS[j][5:3]));
            wr(3'd2, 32'h10000 | 32'(VECS[j][2:0]));
            wait_idle();
            check("R2 word count", 32'(s_word - base), 32'(VECS[j][2:0]));
            for (int w = 0; w < int'(VECS[j][2:0]); w++) begin
                rd(3'd5, v);
                check("R7 R4 rx word", v, exp_swap(VECS[j][5:3], pat(base + w)));
            end
        end
        wr(3'd1, 32'h0);

        // R13 transmit off holds everything
        wr(3'd0, 32'h2);
        wr(3'd2, 32'h10002);
        wr(3'd4, 32'hC0DE1234);
        wr(3'd4, 32'h0BADF00D);
        base = s_word;
        repeat (300) @(negedge clk);
        rd(3'd3, v); check("R13 R3 tx level held", v, 32'h00000080);
        rd(3'd2, v); check("R13 pkt held", v, 32'h00010002);
        check("R13 no words", 32'(s_word - base), 32'd0);

        // R6 queued words first, in order
        wr(3'd0, 32'h3);
        wait_idle();
        check("R6 first out", cap[base % 64], 32'hC0DE1234);
        check("R6 second out", cap[(base + 1) % 64], 32'h0BADF00D);
        rd(3'd3, v); check("R6 R3 done, rx 2", v, 32'h00010001);
        rd(3'd5, v); check("R4 rx a", v, pat(base));
        rd(3'd5, v); check("R4 rx b", v, pat(base + 1));

        // R5 filler
        base = s_word;
        wr(3'd2, 32'h10001);
        wait_idle();
        check("R5 filler", cap[base % 64], 32'hFFFFFFFF);
        rd(3'd5, v); check("R5 rx", v, pat(base));

        // R13 receive off discards
        wr(3'd0, 32'h1);
        base = s_word;
        wr(3'd2, 32'h10001);
        wait_idle();
        check("R13 clocked", 32'(s_word - base), 32'd1);
        rd(3'd3, v); check("R13 rx not stored", v, 32'h1);

        // R8 stall on full receive FIFO
        wr(3'd0, 32'h3);
        base = s_word;
        wr(3'd2, 32'h10014);
        for (int i = 0; i < 2000; i++) begin
            rd(3'd3, v);
            if (v[21:15] == 7'd16) break;
        end
        repeat (300) @(negedge clk);
        rd(3'd3, v); check("R8 R3 rx full", v, 32'h00080001);
        rd(3'd2, v); check("R8 count held", v, 32'h00010004);
        check("R8 sclk idle", 32'(spi_sclk), 32'd0);
        for (int w = 0; w < 16; w++) begin
            rd(3'd5, v); check("R8 first block", v, pat(base + w));
        end
        wait_idle();
        for (int w = 16; w < 20; w++) begin
            rd(3'd5, v); check("R8 resumed", v, pat(base + w));
        end

        // R9 underrun
        rd(3'd5, v); check("R9 empty read", v, 32'd0);
        rd(3'd3, v); check("R9 sticky set", v, 32'h3);
        repeat (20) @(negedge clk);
        rd(3'd3, v); check("R9 sticky held", v, 32'h3);

        // R10 soft reset
        base = s_word;
        wr(3'd2, 32'h10001);
        wait_idle();
        wr(3'd0, 32'h2);
        wr(3'd4, 32'h12345678);
        rd(3'd3, v); check("R10 before", v, 32'h00008042);
        wr(3'd0, 32'hA);
        wr(3'd0, 32'h2);
        rd(3'd3, v); check("R10 flushed", v, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule